// File: doc/BRIEF.md
# GAL Row Programming Sequencer

This block writes a single row of a GAL-style programmable logic device. The host raises `start` for one cycle while it presents a six-bit row address, a row bit pattern of `ROW_BITS` bits and a flag that picks the long erase pulse. The block copies the request and raises the program/verify select. It holds the row address on the device lines and shifts the pattern out one bit per serial clock pulse, starting from bit 0. After the last bit it fires one timed, active-low programming strobe, releases it, and drops the select again.

Erase and security-fuse rows use the same engine. The host chooses the address for them, and the erase flag stretches the strobe. The lead time before the first bit, the data setup time, the clock high time and both strobe lengths are parameters. The two strobe lengths are given in milliseconds together with the clock frequency in kHz. Generating the programming voltage and reading rows back are left to other logic.

Top module: `gal_rowwr`

## Requirements
- R1: After reset, and whenever `busy` is low, the device lines rest idle: `pv_sel`=0, `strobe_n`=1, `sclk`=0, `sdin`=0 and `row_addr`=0.
- R2: A `start` sampled while `busy` is low is accepted, and `busy` is high in the next cycle. Address, pattern and erase flag are captured at that edge. Later changes on those inputs have no effect on the running operation.
- R3: `pv_sel` is high in every cycle in which `busy` is high, including every strobe cycle.
- R4: `row_addr` shows the captured address, unchanged, for the whole operation. It is present for `LEAD_CYC` cycles plus the first setup time before the first `sclk` rise.
- R5: Pattern bit k (bit 0 first) is on `sdin` for `SETUP_CYC` cycles with `sclk` low. It is then held while `sclk` is high for `CLKHI_CYC` cycles. Before the first bit, `sclk` stays low for `LEAD_CYC`+`SETUP_CYC` cycles.
- R6: Each operation gives exactly `ROW_BITS` `sclk` pulses, and all of them come before the strobe.
- R7: The strobe is low for `CLK_KHZ`*`PROG_MS` cycles when the erase flag was 0 and for `CLK_KHZ`*`ERASE_MS` cycles when it was 1 (by default 100 ms).
- R8: `strobe_n` falls only once per operation, and never while `sclk` is high.
- R9: After the strobe is released there is one further cycle with `pv_sel` high. Then `busy` falls and `done` is high for exactly one cycle. The operation lasts `LEAD_CYC`+`ROW_BITS`*(`SETUP_CYC`+`CLKHI_CYC`)+pulse+1 busy cycles.
- R10: A `start` while `busy` is high is ignored, including on the last busy cycle. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| erase | input | 1 | Select the erase strobe length |
| addr_in | input | 6 | Row address of the request |
| row_in | input | ROW_BITS | Row pattern, bit 0 shifted first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pv_sel | output | 1 | Program/verify select to the device |
| row_addr | output | 6 | Row address lines to the device |
| sdin | output | 1 | Serial data to the device |
| sclk | output | 1 | Serial clock to the device |
| strobe_n | output | 1 | Active-low programming strobe |

## Verification
Two events can land on the same cycle: the end of one operation and a new request. The bench raises `start` on the single tail cycle that follows the strobe release and checks that no second operation follows. It raises `start` again in the cycle where `done` is high and checks that a full, correct operation is launched with the new address and pattern. All 64 patterns and all 64 addresses of a six-bit configuration are swept, with both strobe lengths. Each bit, pulse width and strobe length is rebuilt from the pins and compared with arithmetic expectations.

// File: rtl/gal_rowwr_pkg.sv
package gal_rowwr_pkg;

    localparam int ADDR_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_CLKHI  = 3'd3,
        ST_STROBE = 3'd4,
        ST_TAIL   = 3'd5
    } rw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              erase;
    } rw_op_s;

    typedef struct packed {
        logic              pv_sel;
        logic [ADDR_W-1:0] row_addr;
        logic              sdin;
        logic              sclk;
        logic              strobe_n;
    } rw_pins_s;

    function automatic int ms_to_cycles(input int khz, input int ms);
        return khz * ms;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gal_rowwr_timer.sv
module gal_rowwr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/gal_rowwr_shifter.sv
module gal_rowwr_shifter #(
    parameter int ROW_BITS = 132
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap,
    input  logic [ROW_BITS-1:0] row_in,
    input  logic                adv,
    output logic                bit_out,
    output logic                last_bit
);
    localparam int IW = (ROW_BITS > 1) ? $clog2(ROW_BITS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(ROW_BITS - 1);

    logic [ROW_BITS-1:0] sreg;
    logic [IW-1:0]       idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            idx  <= '0;
        end else if (cap) begin
            sreg <= row_in;
            idx  <= '0;
        end else if (adv) begin
            sreg <= {1'b0, sreg[ROW_BITS-1:1]};
            idx  <= idx + 1'b1;
        end
    end

    assign bit_out  = sreg[0];
    assign last_bit = (idx == LAST_IDX);

    // R6: the bit index never runs past the last row bit
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX);
endmodule

// File: rtl/gal_rowwr_fsm.sv
module gal_rowwr_fsm
    import gal_rowwr_pkg::*;
#(
    parameter int TW        = 8,
    parameter int LEAD_CYC  = 4,
    parameter int SETUP_CYC = 2,
    parameter int CLKHI_CYC = 2,
    parameter int PROG_P    = 10,
    parameter int ERASE_P   = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          erase_q,
    input  logic          tmr_zero,
    input  logic          last_bit,
    output rw_state_e     state,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          cap,
    output logic          adv,
    output logic          done
);
    localparam logic [TW-1:0] LEAD_V  = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0] SETUP_V = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] HI_V    = TW'(CLKHI_CYC - 1);
    localparam logic [TW-1:0] PROG_V  = TW'(PROG_P - 1);
    localparam logic [TW-1:0] ERASE_V = TW'(ERASE_P - 1);

    rw_state_e nxt;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        adv      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt      = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = LEAD_V;
                    cap      = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_V;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_CLKHI;
                    tmr_load = 1'b1;
                    tmr_val  = HI_V;
                end
            end
            ST_CLKHI: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        nxt     = ST_STROBE;
                        tmr_val = erase_q ? ERASE_V : PROG_V;
                    end else begin
                        nxt     = ST_SETUP;
                        tmr_val = SETUP_V;
                        adv     = 1'b1;
                    end
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    nxt = ST_TAIL;
                end
            end
            ST_TAIL: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_TAIL);
        end
    end

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/gal_rowwr.sv
module gal_rowwr
    import gal_rowwr_pkg::*;
#(
    parameter int ROW_BITS  = 132,
    parameter int LEAD_CYC  = 4,
    parameter int SETUP_CYC = 2,
    parameter int CLKHI_CYC = 2,
    parameter int CLK_KHZ   = 125000,
    parameter int PROG_MS   = 10,
    parameter int ERASE_MS  = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                erase,
    input  logic [5:0]          addr_in,
    input  logic [ROW_BITS-1:0] row_in,
    output logic                busy,
    output logic                done,
    output logic                pv_sel,
    output logic [5:0]          row_addr,
    output logic                sdin,
    output logic                sclk,
    output logic                strobe_n
);
    localparam int PROG_P  = ms_to_cycles(CLK_KHZ, PROG_MS);
    localparam int ERASE_P = ms_to_cycles(CLK_KHZ, ERASE_MS);
    localparam int MAXC    = max2(max2(PROG_P, ERASE_P),
                                  max2(LEAD_CYC, max2(SETUP_CYC, CLKHI_CYC)));
    localparam int TW      = $clog2(MAXC + 1);

    rw_state_e     state;
    rw_op_s        op_q;
    rw_pins_s      pins;
    logic          tmr_load, tmr_zero, cap, adv, bit_out, last_bit;
    logic [TW-1:0] tmr_val;

    gal_rowwr_fsm #(
        .TW(TW), .LEAD_CYC(LEAD_CYC), .SETUP_CYC(SETUP_CYC),
        .CLKHI_CYC(CLKHI_CYC), .PROG_P(PROG_P), .ERASE_P(ERASE_P)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .erase_q(op_q.erase),
        .tmr_zero(tmr_zero), .last_bit(last_bit), .state(state),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .cap(cap), .adv(adv),
        .done(done)
    );

    gal_rowwr_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    gal_rowwr_shifter #(.ROW_BITS(ROW_BITS)) u_shf (
        .clk(clk), .rst(rst), .cap(cap), .row_in(row_in), .adv(adv),
        .bit_out(bit_out), .last_bit(last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (cap) begin
            op_q.addr  <= addr_in;
            op_q.erase <= erase;
        end
    end

    always_comb begin
        pins          = '0;
        pins.strobe_n = 1'b1;
        if (state != ST_IDLE) begin
            pins.pv_sel   = 1'b1;
            pins.row_addr = op_q.addr;
            pins.sdin     = (state == ST_SETUP || state == ST_CLKHI) && bit_out;
            pins.sclk     = (state == ST_CLKHI);
            pins.strobe_n = (state != ST_STROBE);
        end
    end

    assign busy     = (state != ST_IDLE);
    assign pv_sel   = pins.pv_sel;
    assign row_addr = pins.row_addr;
    assign sdin     = pins.sdin;
    assign sclk     = pins.sclk;
    assign strobe_n = pins.strobe_n;

    // strobe-low run counter for the pulse-length check
    logic [TW-1:0] lo_cnt;
    always_ff @(posedge clk) begin
        if (rst)            lo_cnt <= '0;
        else if (!strobe_n) lo_cnt <= lo_cnt + 1'b1;
        else                lo_cnt <= '0;
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pv_sel && strobe_n && !sclk && !sdin && row_addr == '0));
    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);
    assert_select_frame_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> pv_sel);
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(row_addr));
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
        sclk && $past(sclk) |-> $stable(sdin));
    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> lo_cnt == (op_q.erase ? TW'(ERASE_P) : TW'(PROG_P)));
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(sclk && !strobe_n));
    assert_fall_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy && start && state != ST_TAIL |=> busy);
endmodule

// File: tb/gal_rowwr_tb.sv
module gal_rowwr_tb;
    localparam int NB    = 6;
    localparam int LEAD  = 2;
    localparam int SETUP = 2;
    localparam int HI    = 1;
    localparam int KHZ   = 1;
    localparam int PMS   = 3;
    localparam int EMS   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic erase = 1'b0;
    logic [5:0] addr_in = '0;
    logic [NB-1:0] row_in = '0;
    logic busy, done, pv_sel, sdin, sclk, strobe_n;
    logic [5:0] row_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit pend = 0;
    logic [5:0] nx_a;
    logic [NB-1:0] nx_d;
    logic nx_e;

    always #4 clk = ~clk;

    gal_rowwr #(
        .ROW_BITS(NB), .LEAD_CYC(LEAD), .SETUP_CYC(SETUP), .CLKHI_CYC(HI),
        .CLK_KHZ(KHZ), .PROG_MS(PMS), .ERASE_MS(EMS)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .erase(erase), .addr_in(addr_in),
        .row_in(row_in), .busy(busy), .done(done), .pv_sel(pv_sel),
        .row_addr(row_addr), .sdin(sdin), .sclk(sclk), .strobe_n(strobe_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(!busy && !pv_sel && strobe_n && !sclk && !sdin && row_addr == 0, tag,
            {busy, pv_sel, strobe_n, sclk, sdin}, 5'b00100);
    endtask

    // mode: 0 plain, 1 start mid-op, 2 start on tail cycle, 3 start in done cycle
    task automatic run_op(input logic [5:0] a, input logic [NB-1:0] d,
                          input logic e, input int mode);
        int busy_n = 0, pulses = 0, hi_run = 0, lo_run = 0, st_lo = 0, st_ev = 0;
        int guard = 0;
        int plen = e ? KHZ * EMS : KHZ * PMS;
        int exp_busy = LEAD + NB * (SETUP + HI) + plen + 1;
        bit fin = 0, moved = 0, poked = 0, chained = pend;
        logic prev_sclk = 0, prev_stb = 1, prev_sdin = 0;
        logic [NB-1:0] got = '0;
        if (!pend) begin
            @(negedge clk);
            start = 1'b1; addr_in = a; row_in = d; erase = e;
        end
        pend = 0;
        @(negedge clk);
        start = 1'b0; addr_in = ~a; row_in = ~d; erase = ~e;
        chk(busy == 1'b1, chained ? "R10 start in done cycle accepted" : "R2 busy after start",
            busy, 1);
        while (!fin && guard < 2000) begin
            guard++;
            if (busy) begin
                busy_n++;
                if (!pv_sel) chk(0, "R3 select high while busy", pv_sel, 1);
                if (row_addr != a) chk(0, "R4 address held", row_addr, a);
                if (sclk && !prev_sclk) begin
                    if (pulses < NB) got[pulses] = sdin;
                    chk(lo_run == (pulses == 0 ? LEAD + SETUP : SETUP), "R5 setup before rise",
                        lo_run, pulses == 0 ? LEAD + SETUP : SETUP);
                    if (pulses > 0 && moved) chk(0, "R5 data stable in setup", 1, 0);
                    pulses++;
                    hi_run = 1;
                end else if (sclk) begin
                    if (sdin != prev_sdin) chk(0, "R5 data held while clock high", sdin, prev_sdin);
                    hi_run++;
                end else if (prev_sclk) begin
                    chk(hi_run == HI, "R5 clock high width", hi_run, HI);
                    lo_run = 1;
                    moved = 0;
                end else begin
                    lo_run++;
                    if (sdin != prev_sdin) moved = 1;
                end
                if (!strobe_n) begin
                    if (prev_stb) begin
                        st_ev++;
                        chk(pulses == NB, "R6 all pulses before strobe", pulses, NB);
                    end
                    st_lo++;
                    if (sclk) chk(0, "R8 clock during strobe", 1, 0);
                end else if (!prev_stb) begin
                    chk(st_lo == plen, "R7 strobe length", st_lo, plen);
                    chk(pv_sel, "R9 tail cycle select high", pv_sel, 1);
                    if (mode == 2) begin
                        start = 1'b1; addr_in = a ^ 6'h15; row_in = ~d; poked = 1;
                    end
                end
                if (mode == 1 && busy_n == 3) begin
                    start = 1'b1; addr_in = a ^ 6'h2a; row_in = ~d; poked = 1;
                end
            end else if (done) begin
                fin = 1;
                if (mode == 3) begin
                    start = 1'b1; addr_in = nx_a; row_in = nx_d; erase = nx_e; pend = 1;
                end
            end
            prev_sclk = sclk; prev_stb = strobe_n; prev_sdin = sdin;
            if (!fin) begin
                @(negedge clk);
                if (poked) begin start = 1'b0; poked = 0; end
            end
        end
        chk(fin, "R9 done seen", fin, 1);
        chk(busy_n == exp_busy, "R9 busy length", busy_n, exp_busy);
        chk(got == d, "R5 bits shifted LSB first", got, d);
        chk(pulses == NB, "R6 pulse count", pulses, NB);
        chk(st_ev == 1, "R8 single strobe", st_ev, 1);
        if (mode != 3) begin
            @(negedge clk);
            chk(!done, "R9 done one cycle", done, 0);
            chk_idle("R1 idle after op");
            if (mode == 1 || mode == 2) begin
                for (int k = 0; k < 4; k++) begin
                    chk(!busy, "R10 start while busy ignored", busy, 0);
                    @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 reset state");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 idle after reset");
        for (int i = 0; i < 64; i++) begin
            run_op(6'((i * 37 + 5) & 63), NB'(i), i[0], 0);
        end
        run_op(6'h3b, 6'b101101, 1'b1, 1);
        run_op(6'h3d, 6'b010011, 1'b0, 2);
        nx_a = 6'h27; nx_d = 6'b110001; nx_e = 1'b1;
        run_op(6'h01, 6'b011110, 1'b0, 3);
        run_op(nx_a, nx_d, nx_e, 0);
        run_op(6'h00, 6'b000000, 1'b0, 0);
        run_op(6'h3f, 6'b111111, 1'b1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule